// File: doc/BRIEF.md
# Subset 32-bit Integer Processor Core

This block is a compact 32-bit processor that runs a reduced integer instruction set, one instruction per clock. In each cycle it presents the program counter on a word-wide instruction port and decodes the word that comes back. It reads up to two operands from a 32-entry register file and computes a result. It then writes the result back, or moves a word through a separate data-memory port. Both memory ports are expected to answer combinationally within the cycle. Stores are committed by the memory on the next rising edge.

The supported operations are register add and subtract, each in a checked form and a wrapping form, and a left shift by a constant. It also supports add-immediate in a signed form and a wrapping form, OR-immediate, and load of an upper half. Finally there are word load, word store, and equal/not-equal branches. Every branch has one delay slot: the word after a branch always runs, and a taken branch lands relative to that word's address. Two one-cycle pulses report problems. One marks a checked add or subtract that overflowed. The other marks a word the core does not recognise.

Top module: `core_top`

## Requirements
- R1: After reset the first fetch is at address 0. Without a taken branch, each later fetch address is the previous one plus 4, and fetch addresses are always word aligned.
- R2: Opcode 0 with funct 32 (add), 33 (addu), 34 (sub) or 35 (subu) writes register rd (bits 15..11) with rs (bits 25..21) plus or minus rt (bits 20..16), wrapping modulo 2^32.
- R3: On signed overflow, add and sub leave rd unchanged and raise ovf_flag for exactly the one cycle after the instruction. addu and subu never raise it.
- R4: Opcode 0 with funct 0 writes rd with rt shifted left by the shamt field (bits 10..6).
- R5: Opcodes 8 and 9 write rt with rs plus the sign-extended 16-bit immediate, wrapping without a flag. Opcode 13 writes rt with rs ORed with the zero-extended immediate.
- R6: Opcode 15 writes rt with the immediate in bits 31..16 and zeros below it, and ignores the rs field.
- R7: Opcode 35 loads rt from dmem_rdata and opcode 43 stores rt through dmem_wdata with dmem_we high for that cycle. In both cases the address is rs plus the sign-extended offset. dmem_we is never high for any other opcode.
- R8: Opcode 4 branches when rs equals rt and opcode 5 branches when they differ. A taken branch goes to branch address + 4 + (sign-extended offset << 2). The word at branch address + 4 executes in every case.
- R9: Register 0 reads as zero, and writes to it are discarded.
- R10: A register written by one instruction holds the new value for the very next instruction.
- R11: An unknown opcode, or opcode 0 with an unknown funct, changes no register and no memory, and raises illegal_flag for the one cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Byte address of the instruction word being fetched |
| imem_data | input | 32 | Instruction word at imem_addr, valid in the same cycle |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Data to store |
| dmem_we | output | 1 | Store strobe, taken by the memory at the next rising edge |
| dmem_rdata | input | 32 | Word read at dmem_addr, valid in the same cycle |
| ovf_flag | output | 1 | One-cycle pulse after a checked add or subtract overflows |
| illegal_flag | output | 1 | One-cycle pulse after an unrecognised instruction |

## Verification
A register write or a store takes effect on the edge that ends the instruction's cycle. The bench therefore judges register results only through later stores. It lets each program run until it reaches its closing branch-to-self loop and then compares the data memory with values computed from the operands. The two flags are registered, so each one is high in the cycle after its cause, while the fetch address already points at the next word. The bench samples them at the falling edge and records that fetch address, which pins each pulse to exactly one cycle. Fetch addresses are also checked once per cycle at the falling edge across a taken branch and its delay slot.

// File: rtl/core_pkg.sv
`timescale 1ns/1ps
package core_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);

    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_BNE   = 6'd5;
    localparam logic [5:0] OPC_ADDI  = 6'd8;
    localparam logic [5:0] OPC_ADDIU = 6'd9;
    localparam logic [5:0] OPC_ORI   = 6'd13;
    localparam logic [5:0] OPC_LUI   = 6'd15;
    localparam logic [5:0] OPC_LW    = 6'd35;
    localparam logic [5:0] OPC_SW    = 6'd43;

    localparam logic [5:0] FN_SLL  = 6'd0;
    localparam logic [5:0] FN_ADD  = 6'd32;
    localparam logic [5:0] FN_ADDU = 6'd33;
    localparam logic [5:0] FN_SUB  = 6'd34;
    localparam logic [5:0] FN_SUBU = 6'd35;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_OR, ALU_SLL, ALU_LUI
    } alu_op_e;

    typedef enum logic [1:0] {
        BSEL_REG, BSEL_SEXT, BSEL_ZEXT
    } bsel_e;

    typedef struct packed {
        alu_op_e           alu_op;
        bsel_e             b_sel;
        logic              chk_ovf;
        logic              reg_we;
        logic [RIDX_W-1:0] wr_idx;
        logic              mem_rd;
        logic              mem_wr;
        logic              br_eq;
        logic              br_ne;
        logic              illegal;
    } ctrl_t;
endpackage

// File: rtl/core_decode.sv
`timescale 1ns/1ps
module core_decode
    import core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] instr,
    output ctrl_t        ctrl
);
    logic [5:0]        opc;
    logic [5:0]        fn;
    logic [RIDX_W-1:0] rt_f;
    logic [RIDX_W-1:0] rd_f;

    assign opc  = instr[31:26];
    assign fn   = instr[5:0];
    assign rt_f = instr[20:16];
    assign rd_f = instr[15:11];

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        ctrl.b_sel  = BSEL_REG;
        case (opc)
            OPC_RTYPE: begin
                ctrl.wr_idx = rd_f;
                ctrl.reg_we = 1'b1;
                case (fn)
                    FN_ADD:  begin ctrl.alu_op = ALU_ADD; ctrl.chk_ovf = 1'b1; end
                    FN_ADDU: ctrl.alu_op = ALU_ADD;
                    FN_SUB:  begin ctrl.alu_op = ALU_SUB; ctrl.chk_ovf = 1'b1; end
                    FN_SUBU: ctrl.alu_op = ALU_SUB;
                    FN_SLL:  ctrl.alu_op = ALU_SLL;
                    default: begin ctrl.reg_we = 1'b0; ctrl.illegal = 1'b1; end
                endcase
            end
            OPC_ADDI, OPC_ADDIU: begin
                ctrl.wr_idx = rt_f;
                ctrl.reg_we = 1'b1;
                ctrl.b_sel  = BSEL_SEXT;
            end
            OPC_ORI: begin
                ctrl.wr_idx = rt_f;
                ctrl.reg_we = 1'b1;
                ctrl.b_sel  = BSEL_ZEXT;
                ctrl.alu_op = ALU_OR;
            end
            OPC_LUI: begin
                ctrl.wr_idx = rt_f;
                ctrl.reg_we = 1'b1;
                ctrl.b_sel  = BSEL_ZEXT;
                ctrl.alu_op = ALU_LUI;
            end
            OPC_LW: begin
                ctrl.wr_idx = rt_f;
                ctrl.reg_we = 1'b1;
                ctrl.b_sel  = BSEL_SEXT;
                ctrl.mem_rd = 1'b1;
            end
            OPC_SW: begin
                ctrl.b_sel  = BSEL_SEXT;
                ctrl.mem_wr = 1'b1;
            end
            OPC_BEQ: ctrl.br_eq = 1'b1;
            OPC_BNE: ctrl.br_ne = 1'b1;
            default: ctrl.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/core_alu.sv
`timescale 1ns/1ps
module core_alu
    import core_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int SW = $clog2(W)
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [SW-1:0] shamt,
    output logic [W-1:0]  res,
    output logic          ovf
);
    logic [W-1:0] sum;
    logic [W-1:0] dif;

    assign sum = a + b;
    assign dif = a - b;

    always_comb begin
        ovf = 1'b0;
        case (op)
            ALU_ADD: begin
                res = sum;
                ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
            end
            ALU_SUB: begin
                res = dif;
                ovf = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
            end
            ALU_OR:  res = a | b;
            ALU_SLL: res = b << shamt;
            ALU_LUI: res = b << (W / 2);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/core_regfile.sv
`timescale 1ns/1ps
module core_regfile #(
    parameter int W  = 32,
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ra_idx,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  ra_val,
    output logic [W-1:0]  rb_val,
    input  logic          we,
    input  logic [IW-1:0] w_idx,
    input  logic [W-1:0]  w_val
);
    logic [W-1:0] regs_q [N];
    logic [W-1:0] regs_d [N];

    always_comb begin
        regs_d = regs_q;
        if (we && (w_idx != '0)) begin
            regs_d[w_idx] = w_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ra_val = (ra_idx == '0) ? '0 : regs_q[ra_idx];
    assign rb_val = (rb_idx == '0) ? '0 : regs_q[rb_idx];
endmodule

// File: rtl/core_top.sv
`timescale 1ns/1ps
module core_top
    import core_pkg::*;
#(
    parameter int          W        = XLEN,
    parameter int          N        = NREG,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] imem_addr,
    input  logic [W-1:0] imem_data,
    output logic [W-1:0] dmem_addr,
    output logic [W-1:0] dmem_wdata,
    output logic         dmem_we,
    input  logic [W-1:0] dmem_rdata,
    output logic         ovf_flag,
    output logic         illegal_flag
);
    localparam int IW    = $clog2(N);
    localparam int SW    = $clog2(W);
    localparam int IMM_W = 16;
    localparam int BYTES = W / 8;

    typedef struct packed {
        logic [W-1:0] pc;
        logic [W-1:0] npc;
        logic         ovf;
        logic         ill;
    } state_t;

    state_t st_d, st_q;

    ctrl_t             ctrl;
    logic [IW-1:0]     rs_idx, rt_idx;
    logic [SW-1:0]     shamt;
    logic [IMM_W-1:0]  imm;
    logic [W-1:0]      imm_sext, imm_zext;
    logic [W-1:0]      rs_val, rt_val, alu_b, alu_res;
    logic              alu_ovf;
    logic              wb_we;
    logic [W-1:0]      wb_val;
    logic              take;

    assign rs_idx   = imem_data[25:21];
    assign rt_idx   = imem_data[20:16];
    assign shamt    = imem_data[10:6];
    assign imm      = imem_data[15:0];
    assign imm_sext = {{(W-IMM_W){imm[IMM_W-1]}}, imm};
    assign imm_zext = {{(W-IMM_W){1'b0}}, imm};

    core_decode #(.W(W)) u_dec (
        .instr (imem_data),
        .ctrl  (ctrl)
    );

    core_regfile #(.W(W), .N(N)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (rs_idx),
        .rb_idx (rt_idx),
        .ra_val (rs_val),
        .rb_val (rt_val),
        .we     (wb_we),
        .w_idx  (ctrl.wr_idx),
        .w_val  (wb_val)
    );

    always_comb begin
        case (ctrl.b_sel)
            BSEL_SEXT: alu_b = imm_sext;
            BSEL_ZEXT: alu_b = imm_zext;
            default:   alu_b = rt_val;
        endcase
    end

    core_alu #(.W(W)) u_alu (
        .op    (ctrl.alu_op),
        .a     (rs_val),
        .b     (alu_b),
        .shamt (shamt),
        .res   (alu_res),
        .ovf   (alu_ovf)
    );

    assign wb_we  = ctrl.reg_we && !(ctrl.chk_ovf && alu_ovf);
    assign wb_val = ctrl.mem_rd ? dmem_rdata : alu_res;
    assign take   = (ctrl.br_eq && (rs_val == rt_val)) ||
                    (ctrl.br_ne && (rs_val != rt_val));

    always_comb begin
        st_d     = st_q;
        st_d.pc  = st_q.npc;
        st_d.npc = take ? (st_q.npc + (imm_sext << 2)) : (st_q.npc + W'(BYTES));
        st_d.ovf = ctrl.chk_ovf && alu_ovf;
        st_d.ill = ctrl.illegal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc  <= W'(RESET_PC);
            st_q.npc <= W'(RESET_PC) + W'(BYTES);
            st_q.ovf <= 1'b0;
            st_q.ill <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign imem_addr    = st_q.pc;
    assign dmem_addr    = alu_res;
    assign dmem_wdata   = rt_val;
    assign dmem_we      = ctrl.mem_wr;
    assign ovf_flag     = st_q.ovf;
    assign illegal_flag = st_q.ill;
endmodule

// File: rtl/core_checker.sv
`timescale 1ns/1ps
module core_checker
    import core_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_data,
    input logic        dmem_we,
    input logic        ovf_flag,
    input logic        illegal_flag
);
    logic [1:0] age_q;
    logic [5:0] opc;
    logic       is_br;
    logic       known_opc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    assign opc       = imem_data[31:26];
    assign is_br     = (opc == OPC_BEQ) || (opc == OPC_BNE);
    assign known_opc = (opc == OPC_BEQ) || (opc == OPC_BNE) || (opc == OPC_ADDI) ||
                       (opc == OPC_ADDIU) || (opc == OPC_ORI) || (opc == OPC_LUI) ||
                       (opc == OPC_LW) || (opc == OPC_SW);

    AST_PC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        imem_addr[1:0] == 2'b00); // R1

    AST_FETCH_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && !$past(is_br, 2)) |-> imem_addr == $past(imem_addr) + 32'd4); // R1

    AST_DELAY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1 && $past(is_br)) |-> imem_addr == $past(imem_addr) + 32'd4); // R8

    AST_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> opc == OPC_SW); // R7

    AST_OVF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1 && ovf_flag) |-> $past(opc) == OPC_RTYPE); // R3

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_flag && illegal_flag)); // R3

    AST_ILL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1 && illegal_flag) |-> !$past(known_opc)); // R11
endmodule

bind core_top core_checker u_chk (.*);

// File: tb/core_top_test.sv
`timescale 1ns/1ps
module core_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, ovf_flag, illegal_flag;

    logic [31:0] rom [64];
    logic [31:0] ram [64];
    int total = 0;
    int bad = 0;
    int ovf_n = 0;
    int ill_n = 0;
    logic [31:0] ovf_pc [4];
    logic [31:0] ill_pc [4];

    assign imem_data  = rom[imem_addr[7:2]];
    assign dmem_rdata = ram[dmem_addr[7:2]];

    always @(posedge clk) if (dmem_we) ram[dmem_addr[7:2]] <= dmem_wdata;

    core_top uut (.*);

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ovf_flag) begin
                if (ovf_n < 4) ovf_pc[ovf_n] = imem_addr;
                ovf_n++;
            end
            if (illegal_flag) begin
                if (ill_n < 4) ill_pc[ill_n] = imem_addr;
                ill_n++;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
    endfunction

    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic logic sovf_add(logic [31:0] a, logic [31:0] b);
        logic [31:0] s;
        s = a + b;
        return (a[31] == b[31]) && (s[31] != a[31]);
    endfunction

    function automatic logic sovf_sub(logic [31:0] a, logic [31:0] b);
        logic [31:0] s;
        s = a - b;
        return (a[31] != b[31]) && (s[31] != a[31]);
    endfunction

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) begin
            rom[i] = 32'h0;
            ram[i] = 32'hDEADBEEF;
        end
    endtask

    task automatic release_reset();
        repeat (2) @(negedge clk);
        ovf_n = 0;
        ill_n = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // Directed program: branches, delay slots, register 0, illegal words
        hold_reset();
        rom[0]  = enc_i(9, 0, 1, 5);
        rom[1]  = enc_i(9, 0, 2, 5);
        rom[2]  = enc_i(4, 1, 2, 3);       // taken, target index 6
        rom[3]  = enc_i(9, 0, 3, 7);       // delay slot
        rom[4]  = enc_i(9, 0, 4, 9);       // skipped
        rom[5]  = enc_i(9, 0, 4, 10);      // skipped
        rom[6]  = enc_i(5, 1, 2, 2);       // not taken
        rom[7]  = enc_i(9, 0, 5, 11);
        rom[8]  = enc_i(9, 0, 6, 12);
        rom[9]  = enc_i(9, 0, 0, 99);      // write to r0
        rom[10] = enc_i(9, 0, 7, 'h77);
        rom[11] = enc_i(63, 0, 7, 1);      // unknown opcode
        rom[12] = enc_r(0, 0, 7, 0, 63);   // unknown funct
        rom[13] = enc_i(5, 1, 3, 2);       // taken, target index 16
        rom[14] = enc_i(9, 0, 8, 1);       // delay slot
        rom[15] = enc_i(9, 0, 8, 2);       // skipped
        rom[16] = enc_i(9, 0, 11, 'hC0);
        rom[17] = enc_i(43, 11, 3, 0);
        rom[18] = enc_i(43, 11, 4, 4);
        rom[19] = enc_i(43, 11, 5, 8);
        rom[20] = enc_i(43, 11, 6, 12);
        rom[21] = enc_i(43, 11, 7, 16);
        rom[22] = enc_i(43, 11, 8, 20);
        rom[23] = enc_i(43, 0, 0, 'h80);
        rom[24] = enc_i(9, 0, 9, 3);
        rom[25] = enc_r(9, 9, 10, 0, 33);
        rom[26] = enc_i(43, 11, 10, 24);
        rom[27] = enc_i(4, 0, 0, -1);
        repeat (2) @(negedge clk);
        chk("R1 reset fetch address", imem_addr, 32'h0);
        chk("R3 reset ovf_flag", {31'd0, ovf_flag}, 32'd0);
        chk("R11 reset illegal_flag", {31'd0, illegal_flag}, 32'd0);
        release_reset();
        begin
            logic [31:0] trace [8];
            trace = '{32'd0, 32'd4, 32'd8, 32'd12, 32'd24, 32'd28, 32'd32, 32'd36};
            for (int k = 0; k < 8; k++) begin
                chk($sformatf("R1 R8 fetch trace step %0d", k), imem_addr, trace[k]);
                @(negedge clk);
            end
        end
        repeat (50) @(negedge clk);
        chk("R8 delay slot after taken beq", ram[48], 32'd7);
        chk("R8 words past taken beq skipped", ram[49], 32'd0);
        chk("R8 delay slot after untaken bne", ram[50], 32'd11);
        chk("R8 fall through after untaken bne", ram[51], 32'd12);
        chk("R11 illegal words leave r7", ram[52], 32'h77);
        chk("R8 delay slot of taken bne, target skips", ram[53], 32'd1);
        chk("R9 r0 stays zero after write", ram[32], 32'd0);
        chk("R10 value usable by next instruction", ram[54], 32'd6);
        chk("R11 illegal pulse count", ill_n, 32'd2);
        chk("R11 first illegal pulse cycle", ill_pc[0], 32'd48);
        chk("R11 second illegal pulse cycle", ill_pc[1], 32'd52);
        chk("R3 no overflow in directed program", ovf_n, 32'd0);

        // Random operand programs with overflow corners
        for (int it = 0; it < 24; it++) begin
            logic [31:0] a, b, exp_add, exp_sub, sx;
            logic [15:0] imm;
            logic [4:0]  sh;
            logic        oa, os;
            a   = $urandom;
            b   = $urandom;
            imm = 16'($urandom);
            sh  = 5'($urandom);
            case (it)
                0: begin a = 32'h7FFFFFFF; b = 32'h1; end
                1: begin a = 32'h80000000; b = 32'h1; end
                2: begin a = 32'h80000000; b = 32'h80000000; end
                3: begin a = 32'h0; b = 32'h80000000; end
                4: begin a = 32'hFFFFFFFF; b = 32'hFFFFFFFF; imm = 16'h8000; sh = 5'd31; end
                5: begin a = 32'h7FFFFFFF; b = 32'hFFFFFFFF; imm = 16'h7FFF; sh = 5'd0; end
                default: ;
            endcase
            sx = {{16{imm[15]}}, imm};
            oa = sovf_add(a, b);
            os = sovf_sub(a, b);
            exp_add = oa ? 32'h1234 : a + b;
            exp_sub = os ? 32'h4321 : a - b;

            hold_reset();
            rom[0]  = enc_i(15, 0, 1, int'(a[31:16]));
            rom[1]  = enc_i(13, 1, 1, int'(a[15:0]));
            rom[2]  = enc_i(15, 0, 2, int'(b[31:16]));
            rom[3]  = enc_i(13, 2, 2, int'(b[15:0]));
            rom[4]  = enc_r(1, 2, 3, 0, 33);
            rom[5]  = enc_r(1, 2, 4, 0, 35);
            rom[6]  = enc_r(0, 1, 5, int'(sh), 0);
            rom[7]  = enc_i(9, 1, 6, int'(imm));
            rom[8]  = enc_i(13, 1, 7, int'(imm));
            rom[9]  = enc_i(9, 0, 8, 'h1234);
            rom[10] = enc_r(1, 2, 8, 0, 32);
            rom[11] = enc_i(9, 0, 9, 'h4321);
            rom[12] = enc_r(1, 2, 9, 0, 34);
            rom[13] = enc_i(8, 1, 10, int'(imm));
            rom[14] = enc_i(9, 0, 11, 'h60);
            for (int s = 0; s < 8; s++) rom[15 + s] = enc_i(43, 11, 3 + s, -32 + 4 * s);
            rom[23] = enc_i(35, 11, 12, -32);
            rom[24] = 32'h0;
            rom[25] = enc_r(12, 1, 13, 0, 33);
            rom[26] = enc_i(43, 11, 13, 0);
            rom[27] = enc_i(15, 1, 14, int'(imm));
            rom[28] = enc_i(43, 11, 14, 4);
            rom[29] = enc_i(4, 0, 0, -1);
            release_reset();
            repeat (50) @(negedge clk);

            chk($sformatf("R2 addu it%0d", it), ram[16], a + b);
            chk($sformatf("R2 subu it%0d", it), ram[17], a - b);
            chk($sformatf("R4 sll it%0d", it), ram[18], a << sh);
            chk($sformatf("R5 addiu it%0d", it), ram[19], a + sx);
            chk($sformatf("R5 ori it%0d", it), ram[20], a | {16'h0, imm});
            chk($sformatf("R2 R3 add it%0d", it), ram[21], exp_add);
            chk($sformatf("R2 R3 sub it%0d", it), ram[22], exp_sub);
            chk($sformatf("R5 addi wraps it%0d", it), ram[23], a + sx);
            chk($sformatf("R7 R10 load then use it%0d", it), ram[24], a + b + a);
            chk($sformatf("R6 lui it%0d", it), ram[25], {imm, 16'h0});
            chk($sformatf("R3 ovf pulse count it%0d", it), ovf_n, 32'(int'(oa) + int'(os)));
            if (oa) chk($sformatf("R3 add ovf pulse cycle it%0d", it), ovf_pc[0], 32'd44);
            if (os) chk($sformatf("R3 sub ovf pulse cycle it%0d", it), ovf_pc[oa ? 1 : 0], 32'd52);
            chk($sformatf("R11 no illegal pulse it%0d", it), ill_n, 32'd0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule